// File: doc/BRIEF.md
# NAND Flash Multi-Page Boot Copy Engine

This block copies a run of consecutive pages from a small-page NAND flash into a destination memory while the chip boots. A one-cycle `start` pulse captures the first page number, the number of pages and the destination base address. For every page the engine selects the flash and sends the read command and a three-byte address. It then waits a fixed settling time, because the flash ready/busy line is not watched. After that it strobes out one full page of bytes, and each byte goes to the destination as one transfer. The flash is deselected at the end of each page. When the last page has been stored, `done` pulses once.

The flash side is a plain pin interface: active-low chip enable, write strobe and read strobe, the two latch-enable lines that mark command and address bytes, and a split 8-bit data bus with an output enable. The destination side is a valid/ready stream. `wr_valid` rises with a byte and its address, and it stays high until the cycle in which `wr_ready` is also high. Address and data do not change while the transfer waits, and the engine reads no further flash byte until the pending one has been taken. Back-pressure therefore stretches the copy but never drops or reorders data.

Top module: `nand_boot_copy`

## Requirements
- R1: While reset is held and just after it is released, chip enable, write strobe and read strobe are high. Both latch enables, the data output enable, `wr_valid` and `done` are low.
- R2: Each page starts with chip enable going low. After that exactly one byte is latched with command-latch high and address-latch low, and its value is 0x00 (page read).
- R3: After the command, exactly three bytes are latched with address-latch high and command-latch low. In order they are: 0x00; page number bits [7:0], which are byte-offset bits [16:9] for a 512-byte page; and page number bits [13:8], which are byte-offset bits [22:17].
- R4: In the third address byte, every bit that maps above byte-offset bit 22 (bits [7:6] with the default chip range) is sent as zero, whatever the upper bits of the page number are.
- R5: The first read strobe of a page falls no sooner than `WAIT_CYC` cycles after address-latch falls.
- R6: Every write or read strobe stays low for exactly `PULSE_CYC` cycles. The two strobes are never low together. Write data is driven (output enable high) while the write strobe is low and in the cycle it rises.
- R7: Each page gets exactly 512 read strobes. The n-th byte of the run goes to destination address `dest_base + n`, and the address wraps modulo 2^`DEST_AW`.
- R8: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold their values, and no read strobe is issued.
- R9: Chip enable goes high after the last byte of each page. The next page uses the next page number.
- R10: `done` is high for exactly one cycle. It comes after the last destination transfer has been accepted, and chip enable is high at that time.
- R11: A `start` with a page count of zero raises `done` in the cycle after `start` is sampled, and the flash pins do not move.
- R12: A `start` pulse while a copy is running has no effect: the running copy finishes with its own parameters and only one `done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a copy |
| start_page | input | PAGE_W | First page number |
| page_count | input | CNT_W | Number of pages to copy |
| dest_base | input | DEST_AW | Destination address of the first byte |
| done | output | 1 | One-cycle completion pulse |
| nand_ce_n | output | 1 | Flash chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Data driven toward the flash |
| nand_dq_oe | output | 1 | Output enable for `nand_dq_o` |
| nand_dq_i | input | 8 | Data read from the flash |
| wr_valid | output | 1 | Destination byte is valid |
| wr_ready | input | 1 | Destination accepts the byte |
| wr_addr | output | DEST_AW | Destination byte address |
| wr_data | output | 8 | Destination byte |

## Verification
Back-pressure on the destination stream and the end of a page can fall in the same cycle. When the final byte of a page is stalled, the chip-enable release, the page-number step and, on the last page, the `done` pulse all wait behind that one handshake. The bench provokes this by holding `wr_ready` low for twenty cycles on every page's last byte, and separately by granting it only one cycle in three. It then judges the result at the pins: the held byte must not change, no read strobe may appear during the stall, chip enable must rise only after the 512th transfer, and `done` must come once with every byte accounted for.

// File: rtl/nbc_pkg.sv
package nbc_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CE,
    ST_CMD,
    ST_ADDR,
    ST_WAIT,
    ST_READ,
    ST_PUSH,
    ST_END,
    ST_DONE
  } nbc_state_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_PULSE,
    PH_HOLD
  } nbc_phase_e;

  localparam logic [7:0] NBC_CMD_PAGE_READ = 8'h00;

endpackage

// File: rtl/nbc_strobe_seq.sv
module nbc_strobe_seq
  import nbc_pkg::*;
#(
  parameter int PULSE_CYC = 2,
  parameter int HOLD_CYC  = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic active,
  output logic capture,
  output logic fin,
  output logic idle
);

  localparam int LONGEST = (PULSE_CYC > HOLD_CYC) ? PULSE_CYC : HOLD_CYC;
  localparam int CW      = $clog2(LONGEST + 1);
  localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] HOLD_LAST  = CW'(HOLD_CYC - 1);

  nbc_phase_e    phase_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (kick) begin
            phase_q <= PH_PULSE;
            cnt_q   <= '0;
          end
        end
        PH_PULSE: begin
          if (cnt_q == PULSE_LAST) begin
            phase_q <= PH_HOLD;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        PH_HOLD: begin
          if (cnt_q == HOLD_LAST) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign active  = (phase_q == PH_PULSE);
  assign capture = (phase_q == PH_PULSE) && (cnt_q == PULSE_LAST);
  assign fin     = (phase_q == PH_HOLD) && (cnt_q == HOLD_LAST);
  assign idle    = (phase_q == PH_IDLE);

  // R6: a new strobe is never requested over one in flight
  a_r6_kick_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    kick |-> idle);
  // R6: the last low cycle is always followed by the hold phase
  a_r6_pulse_to_hold: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (phase_q == PH_HOLD) && !active);

endmodule

// File: rtl/nbc_wait_timer.sv
module nbc_wait_timer #(
  parameter int WAIT_CYC = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);

  localparam int CW = $clog2(WAIT_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= CW'(WAIT_CYC);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign expired = (cnt_q == '0);

  // R5: the settling count only ever walks down by one per cycle
  a_r5_steady_descent: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));

endmodule

// File: rtl/nbc_addr_fmt.sv
module nbc_addr_fmt #(
  parameter int PAGE_BYTES     = 512,
  parameter int CHIP_ADDR_BITS = 23
) (
  input  logic [CHIP_ADDR_BITS-$clog2(PAGE_BYTES)-1:0] page,
  input  logic [1:0]                                   sel,
  output logic [7:0]                                   addr_byte
);

  localparam int SH      = $clog2(PAGE_BYTES);
  localparam int PG_USED = CHIP_ADDR_BITS - SH;
  localparam int MID_LO  = 9;   // second address byte covers offset bits [16:9]
  localparam int TOP_LO  = 17;  // third address byte covers offset bits [24:17]

  logic [7:0] mid_byte;
  logic [7:0] top_byte;

  for (genvar i = 0; i < 8; i++) begin : g_mid
    localparam int OFF_BIT = MID_LO + i;
    localparam int PG_BIT  = OFF_BIT - SH;
    if (PG_BIT >= 0 && PG_BIT < PG_USED) begin : g_on
      assign mid_byte[i] = page[PG_BIT];
    end else begin : g_off
      assign mid_byte[i] = 1'b0;
    end
  end

  for (genvar i = 0; i < 8; i++) begin : g_top
    localparam int OFF_BIT = TOP_LO + i;
    localparam int PG_BIT  = OFF_BIT - SH;
    if (OFF_BIT < CHIP_ADDR_BITS && PG_BIT >= 0 && PG_BIT < PG_USED) begin : g_on
      assign top_byte[i] = page[PG_BIT];
    end else begin : g_mask
      assign top_byte[i] = 1'b0;
    end
  end

  always_comb begin
    case (sel)
      2'd1:    addr_byte = mid_byte;
      2'd2:    addr_byte = top_byte;
      default: addr_byte = 8'h00;
    endcase
  end

endmodule

// File: rtl/nand_boot_copy.sv
module nand_boot_copy
  import nbc_pkg::*;
#(
  parameter int PAGE_W         = 16,
  parameter int CNT_W          = 16,
  parameter int DEST_AW        = 24,
  parameter int PAGE_BYTES     = 512,
  parameter int CHIP_ADDR_BITS = 23,
  parameter int PULSE_CYC      = 2,
  parameter int HOLD_CYC       = 1,
  parameter int WAIT_CYC       = 10000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [PAGE_W-1:0]  start_page,
  input  logic [CNT_W-1:0]   page_count,
  input  logic [DEST_AW-1:0] dest_base,
  output logic               done,
  output logic               nand_ce_n,
  output logic               nand_cle,
  output logic               nand_ale,
  output logic               nand_we_n,
  output logic               nand_re_n,
  output logic [7:0]         nand_dq_o,
  output logic               nand_dq_oe,
  input  logic [7:0]         nand_dq_i,
  output logic               wr_valid,
  input  logic               wr_ready,
  output logic [DEST_AW-1:0] wr_addr,
  output logic [7:0]         wr_data
);

  localparam int BW      = $clog2(PAGE_BYTES);
  localparam int PG_USED = CHIP_ADDR_BITS - BW;
  localparam logic [BW-1:0] BIDX_LAST = BW'(PAGE_BYTES - 1);

  nbc_state_e         state_q;
  logic [PAGE_W-1:0]  page_q;
  logic [CNT_W-1:0]   rem_q;
  logic [DEST_AW-1:0] dst_q;
  logic [1:0]         aidx_q;
  logic [BW-1:0]      bidx_q;
  logic [7:0]         byte_q;

  logic seq_kick, seq_active, seq_capture, seq_fin, seq_idle;
  logic bus_write, bus_read;
  logic wait_load, wait_done;
  logic [7:0] addr_byte;

  assign bus_write = (state_q == ST_CMD) || (state_q == ST_ADDR);
  assign bus_read  = (state_q == ST_READ);
  assign seq_kick  = seq_idle && (bus_write || bus_read);
  assign wait_load = (state_q == ST_ADDR) && seq_fin && (aidx_q == 2'd2);

  nbc_strobe_seq #(
    .PULSE_CYC(PULSE_CYC),
    .HOLD_CYC (HOLD_CYC)
  ) u_strobe (
    .clk    (clk),
    .rst_n  (rst_n),
    .kick   (seq_kick),
    .active (seq_active),
    .capture(seq_capture),
    .fin    (seq_fin),
    .idle   (seq_idle)
  );

  nbc_wait_timer #(
    .WAIT_CYC(WAIT_CYC)
  ) u_settle (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (wait_load),
    .expired(wait_done)
  );

  nbc_addr_fmt #(
    .PAGE_BYTES    (PAGE_BYTES),
    .CHIP_ADDR_BITS(CHIP_ADDR_BITS)
  ) u_addr (
    .page     (page_q[PG_USED-1:0]),
    .sel      (aidx_q),
    .addr_byte(addr_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      page_q  <= '0;
      rem_q   <= '0;
      dst_q   <= '0;
      aidx_q  <= '0;
      bidx_q  <= '0;
      byte_q  <= '0;
    end else begin
      if (seq_capture && bus_read) begin
        byte_q <= nand_dq_i;
      end
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            if (page_count == '0) begin
              state_q <= ST_DONE;
            end else begin
              page_q  <= start_page;
              rem_q   <= page_count;
              dst_q   <= dest_base;
              aidx_q  <= '0;
              bidx_q  <= '0;
              state_q <= ST_CE;
            end
          end
        end
        ST_CE: state_q <= ST_CMD;
        ST_CMD: begin
          if (seq_fin) state_q <= ST_ADDR;
        end
        ST_ADDR: begin
          if (seq_fin) begin
            if (aidx_q == 2'd2) begin
              aidx_q  <= '0;
              state_q <= ST_WAIT;
            end else begin
              aidx_q <= aidx_q + 2'd1;
            end
          end
        end
        ST_WAIT: begin
          if (wait_done) state_q <= ST_READ;
        end
        ST_READ: begin
          if (seq_fin) state_q <= ST_PUSH;
        end
        ST_PUSH: begin
          if (wr_ready) begin
            dst_q <= dst_q + DEST_AW'(1);
            if (bidx_q == BIDX_LAST) begin
              bidx_q  <= '0;
              state_q <= ST_END;
            end else begin
              bidx_q  <= bidx_q + BW'(1);
              state_q <= ST_READ;
            end
          end
        end
        ST_END: begin
          page_q  <= page_q + PAGE_W'(1);
          rem_q   <= rem_q - CNT_W'(1);
          state_q <= (rem_q == CNT_W'(1)) ? ST_DONE : ST_CE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign nand_ce_n  = !((state_q == ST_CE) || (state_q == ST_CMD) || (state_q == ST_ADDR) ||
                        (state_q == ST_WAIT) || (state_q == ST_READ) || (state_q == ST_PUSH));
  assign nand_cle   = (state_q == ST_CMD);
  assign nand_ale   = (state_q == ST_ADDR);
  assign nand_we_n  = !(seq_active && bus_write);
  assign nand_re_n  = !(seq_active && bus_read);
  assign nand_dq_oe = bus_write && !seq_idle;
  assign nand_dq_o  = (state_q == ST_CMD) ? NBC_CMD_PAGE_READ : addr_byte;

  assign wr_valid = (state_q == ST_PUSH);
  assign wr_addr  = dst_q;
  assign wr_data  = byte_q;
  assign done     = (state_q == ST_DONE);

  // R8: a stalled byte keeps its address and value
  a_r8_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
  // R8: no flash read while a byte waits for the destination
  a_r8_no_read_pending: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> nand_re_n);
  // R7: every accepted byte advances the destination address by one
  a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (wr_addr == $past(wr_addr) + DEST_AW'(1)));
  // R10: completion is a single-cycle pulse
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10: flash deselected and bus released at completion
  a_r10_ce_high_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (nand_ce_n && !nand_dq_oe));
  // R2: command and address latches never overlap
  a_r2_latch_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));
  // R6: at most one strobe low, and write data driven under the write strobe
  a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (nand_we_n || nand_re_n));
  a_r6_we_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> nand_dq_oe);
  // R11: zero page count completes in the next cycle
  a_r11_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start && page_count == '0) |=> done);
  // R12: start during the settling wait leaves the run untouched
  a_r12_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && start) |=> ($stable(dst_q) && $stable(rem_q) && $stable(page_q)));

endmodule

// File: tb/tb_nand_boot_copy.sv
module tb_nand_boot_copy;

  localparam int W_CYC = 300;
  localparam int PULSE = 2;
  localparam int PB    = 512;
  localparam int LIMIT = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] start_page = '0;
  logic [15:0] page_count = '0;
  logic [23:0] dest_base = '0;
  logic        done;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  nand_dq_o, nand_dq_i, wr_data;
  logic        wr_valid;
  logic        wr_ready = 1'b1;
  logic [23:0] wr_addr;

  always #5 clk = ~clk;

  nand_boot_copy #(.WAIT_CYC(W_CYC), .PULSE_CYC(PULSE), .HOLD_CYC(1)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_page(start_page),
    .page_count(page_count), .dest_base(dest_base), .done(done),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o),
    .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  function automatic logic [7:0] patt(input logic [13:0] p, input logic [8:0] o);
    logic [7:0] m;
    m = p[7:0] * 8'h1D;
    return m ^ o[7:0] ^ {1'b0, p[13:7 + 1], o[8]};
  endfunction

  // run configuration, written only by the main sequence
  int          run_id = 0;
  logic [15:0] run_start = '0;
  int          run_pages = 0;
  logic [23:0] run_base = '0;
  int          stall_mode = 0;

  // monitor / responder state, written only by the monitor
  int          seen_id = 0;
  int          cyc = 0;
  int          mon_total = 0, mon_bad = 0;
  int          wr_count = 0, pages_seen = 0, done_cnt = 0, ce_falls = 0, we_rises = 0;
  logic [15:0] rd_idx = '0;
  logic [15:0] exp_page = '0;
  logic [13:0] resp_page = '0;
  logic [7:0]  abyte [3];
  logic [7:0]  last_top = '0;
  int          addr_n = 0, we_lo = 0, re_lo = 0, hold_ct = 0, ale_fall_cyc = 0;
  bit          wait_armed = 0, pend = 0;
  logic [23:0] pend_addr = '0;
  logic [7:0]  pend_data = '0;
  logic        p_we = 1, p_re = 1, p_ale = 0, p_ce = 1, p_done = 0;

  int tb_total = 0, tb_bad = 0;

  assign nand_dq_i = patt(resp_page, rd_idx[8:0]);

  task automatic mchk(input bit ok, input string tag, input int act, input int exp);
    mon_total++;
    if (!ok) begin
      mon_bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic tchk(input bit ok, input string tag, input int act, input int exp);
    tb_total++;
    if (!ok) begin
      tb_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic        nr;
    int          n;
    logic [13:0] pg;
    cyc++;
    if (run_id != seen_id) begin
      seen_id = run_id; wr_count = 0; pages_seen = 0; done_cnt = 0; rd_idx = '0;
      exp_page = run_start; addr_n = 0; wait_armed = 0; pend = 0; hold_ct = 0;
    end
    if (rst_n) begin
      // back-pressure decision for the coming edge
      nr = 1'b1;
      if (stall_mode == 1) nr = ((cyc % 3) == 0);
      else if (stall_mode == 2 && wr_valid && (wr_count % PB) == PB - 1 && hold_ct < 20) begin
        nr = 1'b0; hold_ct++;
      end
      // R8: held byte must not change and no read during a stall
      if (pend) begin
        mchk(wr_valid && wr_addr == pend_addr && wr_data == pend_data,
             "R8 stalled byte changed", int'(wr_addr), int'(pend_addr));
      end
      if (wr_valid) mchk(nand_re_n, "R8 read strobe while byte pending", 0, 1);
      pend = wr_valid && !nr;
      pend_addr = wr_addr; pend_data = wr_data;
      wr_ready <= nr;
      if (wr_valid && nr) begin
        n  = wr_count;
        pg = 14'(run_start + 16'(n / PB));
        mchk(wr_addr == 24'(run_base + 24'(n)), "R7 destination address", int'(wr_addr),
             int'(24'(run_base + 24'(n))));
        mchk(wr_data == patt(pg, 9'(n % PB)), "R7 destination data", int'(wr_data),
             int'(patt(pg, 9'(n % PB))));
        wr_count++; hold_ct = 0;
      end
      // R6 strobe widths and write data
      if (!nand_we_n) we_lo++;
      else if (!p_we) begin
        mchk(we_lo == PULSE, "R6 write strobe width", we_lo, PULSE);
        mchk(nand_dq_oe, "R6 data driven at write strobe rise", 0, 1);
        we_rises++;
        we_lo = 0;
        if (nand_cle && !nand_ale) begin
          mchk(!nand_ce_n, "R2 command with chip enable low", 1, 0);
          mchk(nand_dq_o == 8'h00, "R2 command byte", int'(nand_dq_o), 0);
          addr_n = 0;
        end else if (nand_ale && !nand_cle) begin
          if (addr_n < 3) abyte[addr_n] = nand_dq_o;
          addr_n++;
        end
      end
      if (!nand_re_n) re_lo++;
      else if (!p_re) begin
        mchk(re_lo == PULSE, "R6 read strobe width", re_lo, PULSE);
        re_lo = 0;
        rd_idx = rd_idx + 16'd1;
      end
      if (!nand_re_n && p_re && wait_armed) begin
        mchk(cyc - ale_fall_cyc >= W_CYC, "R5 settle time", cyc - ale_fall_cyc, W_CYC);
        wait_armed = 0;
      end
      if (p_ale && !nand_ale) begin
        mchk(addr_n == 3, "R3 address byte count", addr_n, 3);
        mchk(abyte[0] == 8'h00, "R3 first address byte", int'(abyte[0]), 0);
        mchk(abyte[1] == exp_page[7:0], "R3 second address byte", int'(abyte[1]),
             int'(exp_page[7:0]));
        mchk(abyte[2] == {2'b00, exp_page[13:8]}, "R4 third address byte", int'(abyte[2]),
             int'({2'b00, exp_page[13:8]}));
        last_top = abyte[2];
        resp_page = {abyte[2][5:0], abyte[1]};
        rd_idx = '0;
        wait_armed = 1; ale_fall_cyc = cyc;
      end
      if (!nand_ce_n && p_ce) ce_falls++;
      if (nand_ce_n && !p_ce) begin
        mchk(rd_idx == 16'(PB), "R7 reads per page", int'(rd_idx), PB);
        mchk(wr_count == (pages_seen + 1) * PB, "R9 chip enable after last byte", wr_count,
             (pages_seen + 1) * PB);
        pages_seen++; exp_page = exp_page + 16'd1;
      end
      if (done) begin
        done_cnt++;
        mchk(nand_ce_n, "R10 chip enable high at done", 0, 1);
        mchk(wr_count == run_pages * PB, "R10 done after last transfer", wr_count, run_pages * PB);
      end
      if (p_done && done) mchk(0, "R10 done longer than one cycle", 1, 0);
    end
    p_we = nand_we_n; p_re = nand_re_n; p_ale = nand_ale; p_ce = nand_ce_n; p_done = done;
  end

  // watchdog
  always @(negedge clk) begin
    if (cyc >= LIMIT) begin
      $display("FAIL watchdog expired actual=%0d expected=<%0d", cyc, LIMIT);
      $display("  test done: total=%0d bad=%0d", tb_total + mon_total + 1, tb_bad + mon_bad + 1);
      $finish;
    end
  end

  task automatic run_copy(input logic [15:0] sp, input int cnt, input logic [23:0] base,
                          input int mode);
    @(negedge clk);
    run_start = sp; run_pages = cnt; run_base = base; stall_mode = mode;
    run_id++;
    @(negedge clk);
    start_page = sp; page_count = 16'(cnt); dest_base = base; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 60000 && done_cnt == 0; i++) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    tchk(nand_ce_n && nand_we_n && nand_re_n, "R1 strobes idle in reset", 0, 1);
    tchk(!nand_cle && !nand_ale && !nand_dq_oe, "R1 latches idle in reset", 1, 0);
    tchk(!wr_valid && !done, "R1 outputs idle in reset", 1, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    tchk(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale,
         "R1 pins idle after reset", 0, 1);
    tchk(!wr_valid && !done, "R1 no transfer after reset", 1, 0);
  endtask

  task automatic t_basic();
    run_copy(16'd3, 2, 24'h001000, 0);
    tchk(done_cnt == 1, "R10 one done pulse", done_cnt, 1);
    tchk(wr_count == 2 * PB, "R7 bytes copied", wr_count, 2 * PB);
    tchk(pages_seen == 2, "R9 pages visited", pages_seen, 2);
  endtask

  task automatic t_carry();
    run_copy(16'h00FF, 2, 24'h020000, 0);
    tchk(pages_seen == 2, "R9 pages across carry", pages_seen, 2);
    tchk(last_top == 8'h01, "R3 third byte after carry", int'(last_top), 1);
  endtask

  task automatic t_mask();
    run_copy(16'hFF05, 1, 24'hFFFF00, 0);
    tchk(last_top == 8'h3F, "R4 upper page bits masked", int'(last_top), 8'h3F);
    tchk(wr_count == PB, "R7 wrapped destination bytes", wr_count, PB);
  endtask

  task automatic t_stall_spread();
    run_copy(16'd40, 1, 24'h000200, 1);
    tchk(wr_count == PB && done_cnt == 1, "R8 sparse ready completes", wr_count, PB);
  endtask

  task automatic t_stall_end();
    run_copy(16'd7, 2, 24'h003000, 2);
    tchk(wr_count == 2 * PB && pages_seen == 2, "R8 end-of-page stall completes", wr_count,
         2 * PB);
    tchk(done_cnt == 1, "R10 single done with end stall", done_cnt, 1);
  endtask

  task automatic t_zero();
    int f0, w0;
    f0 = ce_falls; w0 = we_rises;
    @(negedge clk);
    start_page = 16'd9; page_count = 16'd0; dest_base = 24'h000010; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    tchk(done == 1'b1, "R11 done in next cycle", int'(done), 1);
    @(negedge clk);
    tchk(done == 1'b0, "R11 done lasts one cycle", int'(done), 0);
    repeat (10) @(negedge clk);
    tchk(ce_falls == f0 && we_rises == w0 && nand_ce_n, "R11 flash untouched",
         ce_falls - f0, 0);
  endtask

  task automatic t_busy_start();
    int f0;
    @(negedge clk);
    run_start = 16'd20; run_pages = 1; run_base = 24'h004000; stall_mode = 0;
    run_id++;
    @(negedge clk);
    start_page = 16'd20; page_count = 16'd1; dest_base = 24'h004000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 20000 && wr_count < 100; i++) @(negedge clk);
    start_page = 16'd90; page_count = 16'd3; dest_base = 24'h00F000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 60000 && done_cnt == 0; i++) @(negedge clk);
    f0 = ce_falls;
    repeat (60) @(negedge clk);
    tchk(wr_count == PB, "R12 busy start adds no bytes", wr_count, PB);
    tchk(done_cnt == 1, "R12 single done", done_cnt, 1);
    tchk(ce_falls == f0 && nand_ce_n, "R12 no extra page", ce_falls - f0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_carry();
    t_mask();
    t_stall_spread();
    t_stall_end();
    t_zero();
    t_busy_start();
    repeat (5) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", tb_total + mon_total, tb_bad + mon_bad);
    $finish;
  end

endmodule